// File: doc/BRIEF.md
# Configurable Bit-Serial Data Whitener

This block scrambles a serial bit stream one bit per clock. Each accepted data bit is XORed with a key bit drawn from a 16-bit pseudo-random shift register. The same block undoes the scrambling on the receive side, because applying the same key stream a second time restores the original bits. Software-visible configuration picks the feedback polynomial, which register position supplies the key bit, and the 16-bit starting value. A frame-start pulse reloads that starting value at the beginning of every frame.

A byte-reversed variant of the 9-bit sequence is available for links that expect it. In that variant the key stream is produced eight bits at a time and each group of eight is emitted last-bit-first. A per-bit enable lets the surrounding framing logic pass fields such as a header through untouched. A disabled bit consumes no key material. The result appears one cycle after the input bit, together with a valid flag.

Top module: `whiten_lfsr`

## Requirements
- R1: While `rst` is high, and after it, until the first valid bit, `dout_valid` and `dout` are 0.
- R2: `dout_valid` equals `bit_valid` delayed by exactly one clock. `dout` for a valid input appears in that same following cycle.
- R3: With `cfg_poly` = 1 (9-bit mode), the key bit for an enabled valid bit is register bit `cfg_tap`, read before the step. Each step shifts the register left by one and inserts bit8 XOR bit4 at bit 0.
- R4: With `cfg_poly` = 3 (7-bit mode), the key bit is taken the same way. The value inserted at bit 0 is bit6 XOR bit3.
- R5: With `cfg_poly` = 0, every valid bit passes to `dout` unchanged.
- R6: A valid bit with `bit_en` low passes unchanged. It does not advance the register or the byte-group position, so the next enabled bit receives the key bit it would otherwise have had.
- R7: In a cycle with no valid bit and no frame-start pulse, the register holds its value.
- R8: `frame_start` loads `cfg_seed` into the register and restarts the byte-group position. A valid bit presented in the same cycle is whitened with the freshly loaded seed.
- R9: With `cfg_poly` = 2 (byte-reversed mode), the register uses the 9-bit feedback. At the start of each group of eight enabled bits it produces key bits k0..k7, one per step, with k0 taken first. The group's bits then receive k7, k6, …, k0 in that order.
- R10: `cfg_tap` selects any of the 16 register positions 0 to 15 as the key source.
- R11: Feeding the whitened output of a frame back through the block, with the same seed and settings, reproduces the original bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_poly | input | 2 | Mode: 0 off, 1 9-bit, 2 9-bit byte-reversed, 3 7-bit |
| cfg_tap | input | 4 | Register position that supplies the key bit |
| cfg_seed | input | 16 | Value loaded at frame start |
| frame_start | input | 1 | Reload seed and restart the byte group |
| bit_valid | input | 1 | A data bit is presented this cycle |
| bit_en | input | 1 | Whiten this bit (low: pass through, no advance) |
| bit_in | input | 1 | Data bit |
| dout_valid | output | 1 | Output bit valid, one cycle after input |
| dout | output | 1 | Whitened or passed-through bit |

## Verification
The assertions assume the mode changes only together with a frame-start pulse. They also assume the block sees a frame-start pulse before the first enabled bit after reset. This is because the register's stepping rule and group position are defined from the last reload. The stimulus rewrites `cfg_poly` only on rows that also pulse `frame_start`. It starts every scenario with such a pulse. Configuration is changed only between clock edges.

// File: rtl/whiten_pkg.sv
`timescale 1ns/1ps
package whiten_pkg;

    localparam int STATE_W = 16;
    localparam int TAP_W   = $clog2(STATE_W);
    localparam int GROUP   = 8;
    localparam int CNT_W   = $clog2(GROUP);

    typedef enum logic [1:0] {
        POLY_OFF     = 2'd0,
        POLY_PN9     = 2'd1,
        POLY_PN9_REV = 2'd2,
        POLY_P7      = 2'd3
    } poly_e;

    typedef logic [STATE_W-1:0] state_t;

    typedef struct packed {
        logic load;
        logic adv_one;
        logic adv_group;
    } step_ctl_t;

    function automatic state_t lfsr_step(state_t s, poly_e p);
        logic fb;
        case (p)
            POLY_PN9, POLY_PN9_REV: fb = s[8] ^ s[4];
            POLY_P7:                fb = s[6] ^ s[3];
            default:                fb = 1'b0;
        endcase
        if (p == POLY_OFF) return s;
        return {s[STATE_W-2:0], fb};
    endfunction

endpackage

// File: rtl/whiten_state.sv
`timescale 1ns/1ps
module whiten_state
    import whiten_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_ctl_t ctl,
    input  state_t    seed,
    input  poly_e     poly,
    output state_t    cur,
    output state_t    state_q
);
    state_t base;
    state_t nxt;

    always_comb begin
        base = ctl.load ? seed : state_q;
        nxt  = base;
        if (ctl.adv_group) begin
            for (int i = 0; i < GROUP; i++) nxt = lfsr_step(nxt, poly);
        end else if (ctl.adv_one) begin
            nxt = lfsr_step(base, poly);
        end
    end

    assign cur = base;

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= nxt;
    end
endmodule

// File: rtl/whiten_revbuf.sv
`timescale 1ns/1ps
module whiten_revbuf
    import whiten_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  state_t           cur,
    input  logic [TAP_W-1:0] tap,
    input  poly_e            poly,
    output logic             ks,
    output logic             refill
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_eff;
    logic [GROUP-1:0] grp_q;
    logic [GROUP-1:0] fresh;
    state_t           walk;

    always_comb begin
        walk = cur;
        for (int i = 0; i < GROUP; i++) begin
            fresh[i] = walk[tap];
            walk     = lfsr_step(walk, poly);
        end
    end

    assign cnt_eff = load ? '0 : cnt_q;
    assign refill  = (cnt_eff == '0);
    assign ks      = refill ? fresh[GROUP-1] : grp_q[CNT_W'(GROUP-1) - cnt_eff];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            grp_q <= '0;
        end else if (adv) begin
            if (refill) grp_q <= fresh;
            cnt_q <= cnt_eff + CNT_W'(1);
        end else if (load) begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/whiten_lfsr.sv
`timescale 1ns/1ps
module whiten_lfsr
    import whiten_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_poly,
    input  logic [TAP_W-1:0] cfg_tap,
    input  logic [15:0]      cfg_seed,
    input  logic             frame_start,
    input  logic             bit_valid,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             dout_valid,
    output logic             dout
);
    poly_e     poly;
    step_ctl_t ctl;
    state_t    cur;
    state_t    state_q;
    logic      active;
    logic      rev;
    logic      ks_rev;
    logic      ks;
    logic      refill;

    assign poly   = poly_e'(cfg_poly);
    assign active = bit_valid & bit_en & (poly != POLY_OFF);
    assign rev    = (poly == POLY_PN9_REV);

    always_comb begin
        ctl.load      = frame_start;
        ctl.adv_one   = active & ~rev;
        ctl.adv_group = active & rev & refill;
    end

    whiten_state u_state (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .seed    (state_t'(cfg_seed)),
        .poly    (poly),
        .cur     (cur),
        .state_q (state_q)
    );

    whiten_revbuf u_rev (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_start),
        .adv    (active & rev),
        .cur    (cur),
        .tap    (cfg_tap),
        .poly   (poly),
        .ks     (ks_rev),
        .refill (refill)
    );

    assign ks = rev ? ks_rev : cur[cfg_tap];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_valid <= 1'b0;
            dout       <= 1'b0;
        end else begin
            dout_valid <= bit_valid;
            dout       <= bit_valid ? (bit_in ^ (active & ks)) : 1'b0;
        end
    end
endmodule

// File: rtl/whiten_lfsr_chk.sv
`timescale 1ns/1ps
module whiten_lfsr_chk
    import whiten_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frame_start,
    input logic        bit_valid,
    input logic        bit_en,
    input logic        bit_in,
    input logic [1:0]  cfg_poly,
    input logic [15:0] cfg_seed,
    input logic        dout,
    input logic        dout_valid,
    input state_t      state_q
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!dout_valid && !dout));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> dout_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> !dout_valid);

    p_pn9_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && bit_valid && bit_en && cfg_poly == 2'd1)
        |=> state_q == {$past(state_q[14:0]), $past(state_q[8]) ^ $past(state_q[4])});

    p_p7_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && bit_valid && bit_en && cfg_poly == 2'd3)
        |=> state_q == {$past(state_q[14:0]), $past(state_q[6]) ^ $past(state_q[3])});

    p_off_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && cfg_poly == 2'd0) |=> dout == $past(bit_in));

    p_skip_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_en) |=> dout == $past(bit_in));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !(bit_valid && bit_en)) |=> $stable(state_q));

    p_seed_load_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !(bit_valid && bit_en)) |=> state_q == $past(cfg_seed));
endmodule

bind whiten_lfsr whiten_lfsr_chk u_chk (.*);

// File: tb/sim_whiten_lfsr.sv
`timescale 1ns/1ps
module sim_whiten_lfsr;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_poly;
    logic [3:0]  cfg_tap;
    logic [15:0] cfg_seed;
    logic        frame_start, bit_valid, bit_en, bit_in;
    logic        dout_valid, dout;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [15:0] m_s;
    int          m_cnt;
    logic [7:0]  m_grp;

    always #2.5 clk = ~clk;

    whiten_lfsr u0 (.*);

    // row: {mode[1:0], tap[3:0], fs, v, en, d}
    localparam logic [9:0] TBL [0:25] = '{
        10'b01_1000_1_1_1_0, 10'b01_1000_0_1_1_1, 10'b01_1000_0_1_1_0,
        10'b01_1000_0_0_1_0, 10'b01_1000_0_1_0_1, 10'b01_1000_0_1_1_1,
        10'b01_1000_0_1_1_0, 10'b11_0110_1_1_1_1, 10'b11_0110_0_1_1_0,
        10'b11_0110_0_1_1_1, 10'b11_0110_0_1_0_0, 10'b11_0110_0_1_1_0,
        10'b00_0011_1_1_1_1, 10'b00_0011_0_1_1_0, 10'b00_0011_0_1_1_1,
        10'b10_1000_1_1_1_0, 10'b10_1000_0_1_1_1, 10'b10_1000_0_1_1_0,
        10'b10_1000_0_1_0_1, 10'b10_1000_0_1_1_1, 10'b10_1000_0_1_1_0,
        10'b10_1000_0_1_1_0, 10'b10_1000_0_1_1_1, 10'b01_1111_1_1_1_0,
        10'b01_1111_0_1_1_1, 10'b01_0000_0_1_1_1
    };

    function automatic logic [15:0] ref_next(logic [15:0] s, logic [1:0] m);
        logic fb;
        fb = (m == 2'd3) ? (s[6] ^ s[3]) : (s[8] ^ s[4]);
        return {s[14:0], fb};
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // drive one cycle, predict from the requirements, sample after the edge
    task automatic step(input logic fs, input logic v, input logic en,
                        input logic d, input string tag, output logic got);
        logic k;
        logic exp;
        @(negedge clk);
        frame_start = fs; bit_valid = v; bit_en = en; bit_in = d;
        if (fs) begin m_s = cfg_seed; m_cnt = 0; end
        k = 1'b0;
        if (v && en && cfg_poly != 2'd0) begin
            if (cfg_poly == 2'd2) begin
                if (m_cnt == 0) begin
                    for (int i = 0; i < 8; i++) begin
                        m_grp[i] = m_s[cfg_tap];
                        m_s = ref_next(m_s, 2'd1);
                    end
                end
                k = m_grp[7 - m_cnt];
                m_cnt = (m_cnt + 1) % 8;
            end else begin
                k = m_s[cfg_tap];
                m_s = ref_next(m_s, cfg_poly);
            end
        end
        exp = d ^ k;
        @(posedge clk);
        #1;
        check({tag, "/R2"}, dout_valid, v);
        if (v) check(tag, dout, exp);
        got = dout;
        frame_start = 1'b0; bit_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        report();
        $finish;
    end

    initial begin
        logic       g;
        logic [15:0] orig, wht;
        rst = 1'b1; cfg_poly = 2'd0; cfg_tap = 4'd0; cfg_seed = 16'h0;
        frame_start = 0; bit_valid = 0; bit_en = 0; bit_in = 0;
        m_s = '0; m_cnt = 0; m_grp = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", dout_valid, 1'b0);
        check("R1", dout, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1", dout_valid, 1'b0);

        // table walk
        cfg_seed = 16'hACE1;
        for (int i = 0; i < 26; i++) begin
            logic [9:0] e;
            string      tag;
            e = TBL[i];
            cfg_poly = e[9:8];
            cfg_tap  = e[7:4];
            case (e[9:8])
                2'd0: tag = "R5";
                2'd1: tag = "R3";
                2'd2: tag = "R9";
                default: tag = "R4";
            endcase
            if (e[3]) tag = "R8";
            if (!e[1]) tag = "R6";
            if (!e[2]) tag = "R7";
            if (e[7:4] == 4'd15 || e[7:4] == 4'd0) tag = "R10";
            step(e[3], e[2], e[1], e[0], tag, g);
        end

        // long 9-bit run
        cfg_poly = 2'd1; cfg_tap = 4'd8; cfg_seed = 16'h01FF;
        for (int i = 0; i < 40; i++) step(i == 0, 1'b1, 1'b1, (i % 3) == 0, "R3", g);

        // byte-reversed with a restart mid-group
        cfg_poly = 2'd2; cfg_tap = 4'd8; cfg_seed = 16'h00F3;
        for (int i = 0; i < 24; i++) step(i == 0, 1'b1, 1'b1, i[0], "R9", g);
        for (int i = 0; i < 5; i++)  step(1'b0, 1'b1, 1'b1, 1'b0, "R9", g);
        for (int i = 0; i < 10; i++) step(i == 0, 1'b1, 1'b1, 1'b0, "R9", g);

        // 7-bit run
        cfg_poly = 2'd3; cfg_tap = 4'd6; cfg_seed = 16'h007F;
        for (int i = 0; i < 30; i++) step(i == 0, 1'b1, 1'b1, (i % 5) == 1, "R4", g);

        // skipped bit keeps the stream aligned, idle cycle holds it
        cfg_poly = 2'd1; cfg_tap = 4'd3; cfg_seed = 16'h5A5A;
        step(1'b1, 1'b1, 1'b1, 1'b0, "R8", g);
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6", g);
        check("R6", g, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, "R7", g);
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6", g);

        // every tap position reads the seed bit directly at frame start
        cfg_poly = 2'd1; cfg_seed = 16'hB38D;
        for (int t = 0; t < 16; t++) begin
            cfg_tap = 4'(t);
            step(1'b1, 1'b1, 1'b1, 1'b0, "R10", g);
            check("R10", g, cfg_seed[t]);
        end

        // round trip
        cfg_poly = 2'd1; cfg_tap = 4'd5; cfg_seed = 16'h1234;
        orig = 16'hC3A6;
        for (int i = 0; i < 16; i++) begin
            step(i == 0, 1'b1, 1'b1, orig[i], "R11", g);
            wht[i] = g;
        end
        for (int i = 0; i < 16; i++) begin
            step(i == 0, 1'b1, 1'b1, wht[i], "R11", g);
            check("R11", g, orig[i]);
        end

        // reset in mid-stream
        @(negedge clk);
        bit_valid = 1'b1; bit_en = 1'b1; rst = 1'b1;
        @(posedge clk); #1;
        check("R1", dout_valid, 1'b0);
        check("R1", dout, 1'b0);
        @(negedge clk);
        rst = 1'b0; bit_valid = 1'b0;

        report();
        $finish;
    end
endmodule